// File: doc/BRIEF.md
# Paired Dual-Compare 8-Bit Timer

This block holds two identical 8-bit timer channels behind one small register bus. Each channel has an up-counter that advances on one of several count strobes supplied from outside the block, two compare constants (A and B), a control register and a status register. When the counter reaches a compare constant, the channel sets a flag, can drive or toggle its timer output pin, and can clear its counter. Counter wrap-around from all ones to zero sets an overflow flag. Each flag becomes a level interrupt when its enable bit is set.

Software reaches the registers one byte at a time. A word access reaches the same register in both channels at once, so the two compare constants of the pair act as one 16-bit value. A compare constant that is being written in a cycle takes no part in the comparison during that cycle. A flag clears only when software writes 0 to it after it has read it as 1.

Register map: busAddr[3:1] picks the register (0 control, 1 status, 2 compare A, 3 compare B, 4 counter, other values read as 0) and busAddr[0] picks the channel. With busWord high, busAddr[0] is ignored, channel 0 uses bits 15:8 and channel 1 uses bits 7:0. Control register: bit 7 enables the B interrupt, bit 6 the A interrupt, bit 5 the overflow interrupt, bits 4:3 choose the clear condition, and bits 2:0 choose the count strobe. Status register: bit 7 is flag B, bit 6 is flag A, bit 5 is the overflow flag, bit 4 reads 0, bits 3:2 hold the B output action and bits 1:0 hold the A output action.

Top module: `tmrPair`

## Requirements
- R1: After reset, the control, status and counter registers of both channels read 0x00, both compare constants read 0xFF, and tmrOut and all interrupt outputs are low.
- R2: A channel's counter goes up by one at each clock edge where count strobe countTick[s-1] is high, with s being the channel's control bits 2:0 in the range 1 to NUM_TICKS. A value of 0, or any value above NUM_TICKS, holds the counter.
- R3: When the counter first becomes equal to a compare constant, the matching status flag (bit 6 for A, bit 7 for B) is set one clock later.
- R4: In a cycle where the bus writes a compare constant, no match on that constant is detected, even when the counter equals the old value.
- R5: When the counter wraps from 0xFF to 0x00 on a count strobe, the overflow flag (status bit 5) is set at that same edge.
- R6: A status flag clears only when a 0 is written to it after the flag was read as 1. Writing 0 without such a read, or writing 1, leaves the flag unchanged.
- R7: If a flag's event happens in the same cycle as a write that would clear that flag, the flag stays set.
- R8: irqCmpB, irqCmpA and irqOvf of a channel are each high exactly while the flag and its enable bit (control bit 7, 6 or 5) are both 1.
- R9: On a compare event, the output action code of that constant changes tmrOut: 00 keeps the level, 01 drives it low, 10 drives it high, 11 toggles it. When A and B match in the same cycle, only the A action is applied.
- R10: Clear condition 01 clears the counter to 0 at the first count strobe at or after a match-A event. Condition 10 does the same for match B. Condition 11 clears it at the next clock while extClr of that channel is high. Condition 00 never clears it, and extClr then has no effect.
- R11: A word access writes or reads the same register of both channels at once, with channel 0 in bits 15:8 and channel 1 in bits 7:0.
- R12: A bus write to the counter loads its value and takes priority over counting and clearing in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Register select (3:1) and channel (0) |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe, marks status reads for flag clearing |
| busWord | input | 1 | Word access to both channels |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the address |
| countTick | input | NUM_TICKS | Count strobes that control bits 2:0 select from |
| extClr | input | 2 | External counter clear, one per channel |
| tmrOut | output | 2 | Timer output level per channel |
| irqCmpA | output | 2 | Compare-A interrupt per channel |
| irqCmpB | output | 2 | Compare-B interrupt per channel |
| irqOvf | output | 2 | Overflow interrupt per channel |

## Verification
Random strobe patterns are applied under random strobe selections, including stopped and out-of-range codes, from random start values. These show whether the counter tracks the selected strobe and no other. Directed sequences line up an event with a bus write in the same cycle: a compare write exactly when the counter reaches the old constant, and a flag clear exactly when the flag's event fires. These separate the write mask and the set-over-clear priority from plain match behaviour. Cases where both constants are equal, and cases with each output action code, separate the A-over-B priority from the individual actions. Word and byte accesses to the same registers show the lane order.

// File: rtl/tmrPairPkg.sv
package tmrPairPkg;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_CMPA = 3'd2,
    REG_CMPB = 3'd3,
    REG_CNT  = 3'd4
  } regSel_e;

  // strobes from the channel control to its datapath
  typedef struct packed {
    logic             wrCnt;
    logic             wrCmpA;
    logic             wrCmpB;
    logic [CNT_W-1:0] wrData;
    logic             cntEn;
    logic             clrCnt;
  } dpStrobe_t;

  // events reported back by the datapath
  typedef struct packed {
    logic evA;
    logic evB;
    logic evOvf;
  } dpEvent_t;
endpackage

// File: rtl/tmrChanDp.sv
module tmrChanDp
  import tmrPairPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] cmpAQ,
  output logic [CNT_W-1:0] cmpBQ,
  output dpEvent_t         ev
);
  localparam int NUM_CMP = 2;

  logic [CNT_W-1:0] cmpReg [NUM_CMP];
  logic             eqPrev [NUM_CMP];
  logic [NUM_CMP-1:0] cmpWr, eqNow, hit;

  assign cmpWr = {stb.wrCmpB, stb.wrCmpA};

  generate
    for (genvar k = 0; k < NUM_CMP; k++) begin : gCmp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          cmpReg[k] <= '1;
        else if (cmpWr[k])  cmpReg[k] <= stb.wrData;
      end

      // a constant under write takes no part in the comparison
      assign eqNow[k] = (cntQ == cmpReg[k]) && !cmpWr[k];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) eqPrev[k] <= 1'b0;
        else       eqPrev[k] <= eqNow[k];
      end

      assign hit[k] = eqNow[k] && !eqPrev[k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cntQ <= '0;
    else if (stb.wrCnt)  cntQ <= stb.wrData;
    else if (stb.clrCnt) cntQ <= '0;
    else if (stb.cntEn)  cntQ <= cntQ + 1'b1;
  end

  assign cmpAQ = cmpReg[0];
  assign cmpBQ = cmpReg[1];

  assign ev = '{evA:   hit[0],
                evB:   hit[1],
                evOvf: stb.cntEn && !stb.wrCnt && !stb.clrCnt && (cntQ == '1)};
endmodule

// File: rtl/tmrChanCtrl.sv
module tmrChanCtrl
  import tmrPairPkg::*;
#(
  parameter int NUM_TICKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busRd,
  input  regSel_e              regSel,
  input  logic [CNT_W-1:0]     wrByte,
  input  logic [NUM_TICKS-1:0] countTick,
  input  logic                 extClr,
  input  dpEvent_t             ev,
  output dpStrobe_t            stb,
  output logic [CNT_W-1:0]     ctrlQ,
  output logic [CNT_W-1:0]     statQ,
  output logic                 tmrOut,
  output logic                 irqA,
  output logic                 irqB,
  output logic                 irqOvf
);
  localparam int NUM_FLAG = 3;   // index 0 overflow, 1 match A, 2 match B

  logic [NUM_FLAG-1:0] flag, armed, evVec, ie;
  logic [1:0]          osA, osB, clrSel;
  logic [SEL_W-1:0]    clkSel;
  logic                wrCtrl, wrStat, rdStat;
  logic                cntEn, matchClr, clrPend;

  assign ie     = ctrlQ[7:5];
  assign clrSel = ctrlQ[4:3];
  assign clkSel = ctrlQ[SEL_W-1:0];
  assign evVec  = {ev.evB, ev.evA, ev.evOvf};

  assign wrCtrl = busWr && (regSel == REG_CTRL);
  assign wrStat = busWr && (regSel == REG_STAT);
  assign rdStat = busRd && (regSel == REG_STAT);

  always_comb begin
    cntEn = 1'b0;
    for (int t = 0; t < NUM_TICKS; t++)
      if (clkSel == SEL_W'(t + 1)) cntEn = cntEn | countTick[t];
  end

  assign matchClr = (ev.evA && clrSel == 2'b01) || (ev.evB && clrSel == 2'b10);

  always_comb begin
    stb        = '0;
    stb.wrCnt  = busWr && (regSel == REG_CNT);
    stb.wrCmpA = busWr && (regSel == REG_CMPA);
    stb.wrCmpB = busWr && (regSel == REG_CMPB);
    stb.wrData = wrByte;
    stb.cntEn  = cntEn;
    stb.clrCnt = (cntEn && (clrPend || matchClr)) || (clrSel == 2'b11 && extClr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlQ <= '0;
    else if (wrCtrl) ctrlQ <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         clrPend <= 1'b0;
    else if (cntEn)    clrPend <= 1'b0;
    else if (matchClr) clrPend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag  <= '0;
      armed <= '0;
    end else begin
      for (int k = 0; k < NUM_FLAG; k++) begin
        if (evVec[k])
          flag[k] <= 1'b1;
        else if (wrStat && !wrByte[5+k] && armed[k])
          flag[k] <= 1'b0;

        if (wrStat && !wrByte[5+k])
          armed[k] <= 1'b0;
        else if (rdStat && flag[k])
          armed[k] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      osA <= '0;
      osB <= '0;
    end else if (wrStat) begin
      osA <= wrByte[1:0];
      osB <= wrByte[3:2];
    end
  end

  function automatic logic applyAction(input logic [1:0] act, input logic cur);
    case (act)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return !cur;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tmrOut <= 1'b0;
    else if (ev.evA)  tmrOut <= applyAction(osA, tmrOut);
    else if (ev.evB)  tmrOut <= applyAction(osB, tmrOut);
  end

  assign statQ  = {flag[2], flag[1], flag[0], 1'b0, osB, osA};
  assign irqOvf = flag[0] && ie[0];
  assign irqA   = flag[1] && ie[1];
  assign irqB   = flag[2] && ie[2];
endmodule

// File: rtl/tmrPair.sv
module tmrPair
  import tmrPairPkg::*;
#(
  parameter int NUM_TICKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic                 busWord,
  input  logic [15:0]          busWdata,
  output logic [15:0]          busRdata,
  input  logic [NUM_TICKS-1:0] countTick,
  input  logic [1:0]           extClr,
  output logic [1:0]           tmrOut,
  output logic [1:0]           irqCmpA,
  output logic [1:0]           irqCmpB,
  output logic [1:0]           irqOvf
);
  localparam int NUM_CH = 2;

  regSel_e regSel;
  logic [NUM_CH-1:0][CNT_W-1:0] cntQ, ctrlQ, statQ, cmpAQ, cmpBQ, rdByte;

  assign regSel = regSel_e'(busAddr[3:1]);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : gCh
      logic             chSel;
      logic [CNT_W-1:0] wrByte;
      dpStrobe_t        stb;
      dpEvent_t         ev;

      assign chSel = busWord || (busAddr[0] == 1'(c));
      if (c == 0) begin : gHi
        assign wrByte = busWord ? busWdata[15:8] : busWdata[7:0];
      end else begin : gLo
        assign wrByte = busWdata[7:0];
      end

      tmrChanCtrl #(.NUM_TICKS(NUM_TICKS)) uCtrl (
        .clk       (clk),
        .rstN      (rstN),
        .busWr     (busWr && chSel),
        .busRd     (busRd && chSel),
        .regSel    (regSel),
        .wrByte    (wrByte),
        .countTick (countTick),
        .extClr    (extClr[c]),
        .ev        (ev),
        .stb       (stb),
        .ctrlQ     (ctrlQ[c]),
        .statQ     (statQ[c]),
        .tmrOut    (tmrOut[c]),
        .irqA      (irqCmpA[c]),
        .irqB      (irqCmpB[c]),
        .irqOvf    (irqOvf[c])
      );

      tmrChanDp uDp (
        .clk   (clk),
        .rstN  (rstN),
        .stb   (stb),
        .cntQ  (cntQ[c]),
        .cmpAQ (cmpAQ[c]),
        .cmpBQ (cmpBQ[c]),
        .ev    (ev)
      );

      always_comb begin
        case (regSel)
          REG_CTRL: rdByte[c] = ctrlQ[c];
          REG_STAT: rdByte[c] = statQ[c];
          REG_CMPA: rdByte[c] = cmpAQ[c];
          REG_CMPB: rdByte[c] = cmpBQ[c];
          REG_CNT:  rdByte[c] = cntQ[c];
          default:  rdByte[c] = '0;
        endcase
      end
    end
  endgenerate

  always_comb begin
    if (busWord)         busRdata = {rdByte[0], rdByte[1]};
    else if (busAddr[0]) busRdata = {8'h00, rdByte[1]};
    else                 busRdata = {8'h00, rdByte[0]};
  end
endmodule

// File: rtl/tmrPairChecker.sv
module tmrPairChecker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           busWr,
  input logic [NUM_CH-1:0]              extClr,
  input logic [NUM_CH-1:0]              irqCmpA,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cntQ,
  input logic [NUM_CH-1:0][CNT_W-1:0]   ctrlQ,
  input logic [NUM_CH-1:0][CNT_W-1:0]   statQ
);
  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : gChk
      // R2: counter moves by at most one step, or to zero, without a write
      a_r2_small_step: assert property (@(posedge clk) disable iff (!rstN)
        !busWr |=> (cntQ[i] == $past(cntQ[i]) ||
                    cntQ[i] == CNT_W'($past(cntQ[i]) + 1) ||
                    cntQ[i] == '0));

      // R2: strobe select 0 holds the counter
      a_r2_stopped: assert property (@(posedge clk) disable iff (!rstN)
        (ctrlQ[i][2:0] == 3'd0 && !busWr && !extClr[i]) |=> cntQ[i] == $past(cntQ[i]));

      // R5: overflow flag rises only on a wrap from all ones to zero
      a_r5_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
        $rose(statQ[i][5]) |-> ($past(cntQ[i]) == '1 && cntQ[i] == '0));

      // R6: a flag falls only after a bus write
      a_r6_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
        $fell(statQ[i][7]) |-> $past(busWr));

      // R8: interrupt A needs both its flag and its enable
      a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
        irqCmpA[i] |-> (statQ[i][6] && ctrlQ[i][6]));
    end
  endgenerate
endmodule

bind tmrPair tmrPairChecker #(.NUM_CH(2), .CNT_W(8)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busWr   (busWr),
  .extClr  (extClr),
  .irqCmpA (irqCmpA),
  .cntQ    (cntQ),
  .ctrlQ   (ctrlQ),
  .statQ   (statQ)
);

// File: tb/tmrPair_bench.sv
`timescale 1ns/1ps
module tmrPair_bench;
  localparam int NUM_TICKS = 4;
  localparam logic [2:0] R_CTRL = 3'd0, R_STAT = 3'd1, R_CMPA = 3'd2,
                         R_CMPB = 3'd3, R_CNT = 3'd4;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [3:0]           busAddr = '0;
  logic                 busWr = 1'b0, busRd = 1'b0, busWord = 1'b0;
  logic [15:0]          busWdata = '0;
  logic [15:0]          busRdata;
  logic [NUM_TICKS-1:0] countTick = '0;
  logic [1:0]           extClr = '0;
  logic [1:0]           tmrOut, irqCmpA, irqCmpB, irqOvf;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  tmrPair #(.NUM_TICKS(NUM_TICKS)) u_tmrPair (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWord(busWord), .busWdata(busWdata), .busRdata(busRdata),
    .countTick(countTick), .extClr(extClr), .tmrOut(tmrOut),
    .irqCmpA(irqCmpA), .irqCmpB(irqCmpB), .irqOvf(irqOvf)
  );

  function automatic logic [3:0] adr(input logic [2:0] r, input logic ch);
    return {r, ch};
  endfunction

  function automatic logic [7:0] expStep(input logic [7:0] c, input int sel,
                                         input logic [3:0] t);
    if (sel >= 1 && sel <= NUM_TICKS && t[sel-1]) return c + 8'd1;
    return c;
  endfunction

  function automatic logic expAction(input logic [1:0] act, input logic cur);
    case (act)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return !cur;
      default: return cur;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic w);
    @(negedge clk);
    busAddr = a; busWdata = d; busWord = w; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWord = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic w, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWord = w; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0; busWord = 1'b0;
  endtask

  task automatic tickOnce(input int idx);
    @(negedge clk);
    countTick[idx] = 1'b1;
    @(negedge clk);
    countTick = '0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  expCnt;
    logic        expOut;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(adr(R_CTRL, 0), 1'b1, d); chk("R1 control word", d, 16'h0000);
    rd(adr(R_STAT, 0), 1'b1, d); chk("R1 status word", d, 16'h0000);
    rd(adr(R_CNT, 1), 1'b0, d);  chk("R1 counter", d, 16'h0000);
    rd(adr(R_CMPA, 0), 1'b1, d); chk("R1 compare A word", d, 16'hFFFF);
    rd(adr(R_CMPB, 1), 1'b0, d); chk("R1 compare B ch1", d, 16'h00FF);
    chk("R1 outputs", {8'h00, tmrOut, irqCmpA, irqCmpB, irqOvf}, 16'h0000);

    // R2 / R12: random strobe selections and strobe patterns on channel 0
    for (int r = 0; r < 16; r++) begin
      int sel;
      sel = int'($urandom_range(0, 7));
      wr(adr(R_CTRL, 0), 16'(sel), 1'b0);
      expCnt = 8'($urandom_range(0, 255));
      wr(adr(R_CNT, 0), {8'h00, expCnt}, 1'b0);
      rd(adr(R_CNT, 0), 1'b0, d);
      chk("R12 counter load", d, {8'h00, expCnt});
      for (int j = 0; j < 12; j++) begin
        logic [3:0] t;
        t = 4'($urandom_range(0, 15));
        @(negedge clk);
        countTick = t;
        expCnt = expStep(expCnt, sel, t);
      end
      @(negedge clk);
      countTick = '0;
      rd(adr(R_CNT, 0), 1'b0, d);
      chk($sformatf("R2 count sel=%0d", sel), d, {8'h00, expCnt});
    end

    // R6: clear all channel 0 flags through read-then-write
    wr(adr(R_CTRL, 0), 16'h0001, 1'b0);
    rd(adr(R_STAT, 0), 1'b0, d);
    wr(adr(R_STAT, 0), 16'h0000, 1'b0);
    rd(adr(R_STAT, 0), 1'b0, d);
    chk("R6 flags cleared", d, 16'h0000);

    // R3: match B
    wr(adr(R_CMPB, 0), 16'h0005, 1'b0);
    wr(adr(R_CNT, 0), 16'h0004, 1'b0);
    tickOnce(0);
    rd(adr(R_STAT, 0), 1'b0, d);
    chk("R3 flag B on match", d & 16'h00C0, 16'h0080);
    wr(adr(R_STAT, 0), 16'h0000, 1'b0);
    rd(adr(R_STAT, 0), 1'b0, d);
    chk("R6 flag B cleared", d & 16'h0080, 16'h0000);

    // R4: write to compare B in the cycle the counter reaches the old value
    wr(adr(R_CNT, 0), 16'h0004, 1'b0);
    @(negedge clk);
    countTick[0] = 1'b1;
    @(negedge clk);
    countTick = '0;
    busAddr = adr(R_CMPB, 0); busWdata = 16'h0009; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    rd(adr(R_STAT, 0), 1'b0, d);
    chk("R4 no match during compare write", d & 16'h0080, 16'h0000);
    rd(adr(R_CMPB, 0), 1'b0, d);
    chk("R4 new compare value", d, 16'h0009);

    // R8 / R7 / R6 on channel 0 with the B interrupt enabled
    wr(adr(R_CTRL, 0), 16'h0081, 1'b0);
    wr(adr(R_CNT, 0), 16'h0008, 1'b0);
    chk("R8 irq B low without flag", {15'h0, irqCmpB[0]}, 16'h0000);
    tickOnce(0);
    @(negedge clk);
    chk("R8 irq B with flag and enable", {15'h0, irqCmpB[0]}, 16'h0001);
    rd(adr(R_STAT, 0), 1'b0, d);
    wr(adr(R_CNT, 0), 16'h0008, 1'b0);
    @(negedge clk);
    countTick[0] = 1'b1;
    @(negedge clk);
    countTick = '0;
    busAddr = adr(R_STAT, 0); busWdata = 16'h0000; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    @(negedge clk);
    chk("R7 event wins over clear", {15'h0, irqCmpB[0]}, 16'h0001);
    wr(adr(R_STAT, 0), 16'h0000, 1'b0);
    @(negedge clk);
    chk("R6 write 0 without read keeps flag", {15'h0, irqCmpB[0]}, 16'h0001);
    wr(adr(R_STAT, 0), 16'h00E0, 1'b0);
    @(negedge clk);
    chk("R6 write 1 keeps flag", {15'h0, irqCmpB[0]}, 16'h0001);
    rd(adr(R_STAT, 0), 1'b0, d);
    wr(adr(R_STAT, 0), 16'h0000, 1'b0);
    @(negedge clk);
    chk("R6 read then write 0 clears", {15'h0, irqCmpB[0]}, 16'h0000);

    // R10: clear conditions on channel 0
    wr(adr(R_CTRL, 0), 16'h0009, 1'b0);
    wr(adr(R_CMPA, 0), 16'h0003, 1'b0);
    wr(adr(R_CNT, 0), 16'h0002, 1'b0);
    tickOnce(0);
    rd(adr(R_CNT, 0), 1'b0, d);
    chk("R10 counter reaches match A", d, 16'h0003);
    tickOnce(0);
    rd(adr(R_CNT, 0), 1'b0, d);
    chk("R10 clear on match A", d, 16'h0000);
    wr(adr(R_CTRL, 0), 16'h0019, 1'b0);
    wr(adr(R_CNT, 0), 16'h0007, 1'b0);
    @(negedge clk); extClr[0] = 1'b1;
    @(negedge clk); extClr[0] = 1'b0;
    rd(adr(R_CNT, 0), 1'b0, d);
    chk("R10 external clear", d, 16'h0000);
    wr(adr(R_CTRL, 0), 16'h0001, 1'b0);
    wr(adr(R_CNT, 0), 16'h0007, 1'b0);
    @(negedge clk); extClr[0] = 1'b1;
    @(negedge clk); extClr[0] = 1'b0;
    rd(adr(R_CNT, 0), 1'b0, d);
    chk("R10 external clear ignored", d, 16'h0007);

    // R5 / R8 / R6: overflow on channel 1
    wr(adr(R_CTRL, 1), 16'h0002, 1'b0);
    wr(adr(R_CNT, 1), 16'h00FF, 1'b0);
    tickOnce(1);
    @(negedge clk);
    chk("R8 overflow irq masked", {15'h0, irqOvf[1]}, 16'h0000);
    wr(adr(R_CTRL, 1), 16'h0022, 1'b0);
    @(negedge clk);
    chk("R8 overflow irq enabled", {15'h0, irqOvf[1]}, 16'h0001);
    rd(adr(R_CNT, 1), 1'b0, d);
    chk("R5 counter wrapped", d, 16'h0000);
    rd(adr(R_STAT, 1), 1'b0, d);
    chk("R5 overflow flag", d & 16'h0020, 16'h0020);
    wr(adr(R_STAT, 1), 16'h0000, 1'b0);
    @(negedge clk);
    chk("R6 overflow cleared", {15'h0, irqOvf[1]}, 16'h0000);

    // R9: output actions on channel 1
    expOut = 1'b0;
    wr(adr(R_CMPA, 1), 16'h0010, 1'b0);
    wr(adr(R_CMPB, 1), 16'h0010, 1'b0);
    wr(adr(R_STAT, 1), 16'h0006, 1'b0);   // B drives low, A drives high
    wr(adr(R_CNT, 1), 16'h000F, 1'b0);
    tickOnce(1);
    @(negedge clk);
    expOut = expAction(2'b10, expOut);
    chk("R9 A priority on joint match", {15'h0, tmrOut[1]}, {15'h0, expOut});
    wr(adr(R_STAT, 1), 16'h0003, 1'b0);   // A toggles
    wr(adr(R_CNT, 1), 16'h000F, 1'b0);
    tickOnce(1);
    @(negedge clk);
    expOut = expAction(2'b11, expOut);
    chk("R9 A toggle", {15'h0, tmrOut[1]}, {15'h0, expOut});
    wr(adr(R_CMPA, 1), 16'h0030, 1'b0);
    wr(adr(R_STAT, 1), 16'h000C, 1'b0);   // B toggles, A none
    wr(adr(R_CNT, 1), 16'h000F, 1'b0);
    tickOnce(1);
    @(negedge clk);
    expOut = expAction(2'b11, expOut);
    chk("R9 B toggle", {15'h0, tmrOut[1]}, {15'h0, expOut});
    wr(adr(R_STAT, 1), 16'h0004, 1'b0);   // B drives low
    wr(adr(R_CNT, 1), 16'h000F, 1'b0);
    tickOnce(1);
    @(negedge clk);
    expOut = expAction(2'b01, expOut);
    chk("R9 B drive low", {15'h0, tmrOut[1]}, {15'h0, expOut});
    chk("R9 action 00 keeps channel 0 low", {15'h0, tmrOut[0]}, 16'h0000);

    // R11: word access on the compare B pair
    wr(adr(R_CMPB, 0), 16'hA1B2, 1'b1);
    rd(adr(R_CMPB, 0), 1'b0, d); chk("R11 channel 0 upper byte", d, 16'h00A1);
    rd(adr(R_CMPB, 1), 1'b0, d); chk("R11 channel 1 lower byte", d, 16'h00B2);
    rd(adr(R_CMPB, 1), 1'b1, d); chk("R11 word read", d, 16'hA1B2);

    // R12: counter load without a strobe
    wr(adr(R_CNT, 1), 16'h005A, 1'b0);
    rd(adr(R_CNT, 1), 1'b0, d);
    chk("R12 counter load ch1", d, 16'h005A);

    finishRun();
  end
endmodule